// File: doc/BRIEF.md
# Time-Triggered Fault Injection Generator

This block sits inline on a 128-bit state bus inside a cipher datapath and corrupts chosen bits of that state at a chosen moment. Each state bit has its own 2-bit fault code. The code either leaves the bit alone, inverts it, or forces it to 0 or to 1. The moment of injection is set as a cycle offset that is counted from a synchronisation pulse the host cipher raises, for example when its key expansion starts. A length field sets how many consecutive cycles the fault stays applied. A single cycle models a transient upset, and a long window models a wire held stuck.

The user loads the fault codes, the offset and the length with a one-cycle arm strobe. Every sync pulse that arrives while the block is armed clears the cycle counter and starts it again. When the counter enters the programmed window, a registered enable turns on the per-bit selectors, so the state path itself only gains a two-level mux. After the window closes, the block raises its done flag, drops its armed flag and ignores further sync pulses until it is armed again.

Top module: `fault_time_injector`

## Requirements
- R1: Whenever no injection window is open, state_o equals state_i.
- R2: The fault code for state bit i is cfg_kind_i[2i+1:2i]. Code 00 leaves the bit unchanged, 01 inverts it, 10 forces it to 0 and 11 forces it to 1.
- R3: When arm_i is high at a rising clock edge, the codes, offset and length are captured. From that edge on, armed_o is 1, done_o is 0 and the counter is halted until a sync pulse arrives.
- R4: A sync_i pulse sampled while armed clears the counter to zero and starts it. A later sync pulse inside the same arming restarts the count from zero.
- R5: If sync_i is sampled at edge E with offset T and length L, faults are applied in the L cycles that follow edges E+T through E+T+L-1. A length of 0 behaves as 1.
- R6: After arming, and before any sync pulse, no fault is applied.
- R7: At the edge that closes the window, done_o rises and armed_o falls. From then on, sync pulses cause no injection until the next arm.
- R8: During and after reset, armed_o and done_o are 0 and the state passes through untouched.
- R9: When arm_i and sync_i are high at the same edge, arm wins and the sync pulse is ignored.
- R10: The state path holds no register: a change of state_i within a cycle shows up on state_o in that same cycle, with or without a fault applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle strobe that captures the configuration and arms the block |
| cfg_kind_i | input | 256 | Two-bit fault code for each state bit |
| cfg_time_i | input | 16 | Offset in cycles from the sync edge to the first faulty cycle |
| cfg_len_i | input | 8 | Number of faulty cycles (0 is taken as 1) |
| sync_i | input | 1 | Synchronisation pulse from the host cipher |
| state_i | input | 128 | State entering the injection point |
| state_o | output | 128 | State leaving the injection point |
| armed_o | output | 1 | Configuration loaded, injection still pending |
| done_o | output | 1 | The programmed injection has finished |

## Verification
The state output is combinational in state_i. The fault enable, armed_o and done_o all change only at clock edges. If sync is sampled at edge E, the first faulty cycle is the one that follows edge E+T, and done_o is due in the cycle that follows edge E+T+L. The bench drives inputs 1 ns after each rising edge and samples shortly after that. A behavioural model counts cycles from the sync edge, and the bench compares against it on every falling edge. Directed checks index their expectations by the number of edges since the sync edge, and one check changes state_i in the middle of a cycle to confirm the output follows it at once.

// File: rtl/fti_pkg.sv
package fti_pkg;

   typedef enum logic [1:0] {
      FK_NONE = 2'b00,
      FK_FLIP = 2'b01,
      FK_ZERO = 2'b10,
      FK_ONE  = 2'b11
   } fault_kind_e;

   localparam int unsigned KIND_BITS = 2;

   function automatic logic fault_bit(input logic d, input fault_kind_e k);
      logic r;
      case (k)
         FK_FLIP: r = ~d;
         FK_ZERO: r = 1'b0;
         FK_ONE:  r = 1'b1;
         default: r = d;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fti_cfg.sv
module fti_cfg #(
   parameter int unsigned STATE_W = 128,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned LEN_W   = 8,
   localparam int unsigned KIND_W = STATE_W * fti_pkg::KIND_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_i,
   input  logic [KIND_W-1:0]  kind_i,
   input  logic [CNT_W-1:0]   time_i,
   input  logic [LEN_W-1:0]   len_i,
   output logic [KIND_W-1:0]  kind_q,
   output logic [CNT_W-1:0]   time_q,
   output logic [CNT_W:0]     last_q
);
   localparam int unsigned CW1 = CNT_W + 1;

   logic [LEN_W-1:0] len_eff;
   logic [CNT_W:0]   last_d;

   // A zero length is taken as one cycle.
   assign len_eff = (len_i == '0) ? LEN_W'(1) : len_i;
   // The final window count is precomputed, so the timer only tests equality.
   assign last_d  = {1'b0, time_i} + CW1'(len_eff) - CW1'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= '0;
         time_q <= '0;
         last_q <= '0;
      end else if (arm_i) begin
         kind_q <= kind_i;
         time_q <= time_i;
         last_q <= last_d;
      end
   end
endmodule

// File: rtl/fti_timer.sv
module fti_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm_i,
   input  logic           sync_i,
   input  logic [CNT_W-1:0] time_q,
   input  logic [CNT_W:0] last_q,
   output logic           armed_o,
   output logic           done_o,
   output logic           inj_o
);
   logic [CNT_W:0] cnt_q, cnt_n;
   logic           run_q, run_n;
   logic           armed_q, armed_n;
   logic           done_q, done_n;
   logic           inj_q, inj_n;

   always_comb begin
      armed_n = armed_q;
      done_n  = done_q;
      run_n   = run_q;
      cnt_n   = cnt_q;
      if (arm_i) begin
         armed_n = 1'b1;
         done_n  = 1'b0;
         run_n   = 1'b0;
         cnt_n   = '0;
      end else if (armed_q) begin
         if (sync_i) begin
            run_n = 1'b1;
            cnt_n = '0;
         end else if (inj_q && (cnt_q == last_q)) begin
            armed_n = 1'b0;
            done_n  = 1'b1;
            run_n   = 1'b0;
         end else if (run_q && (cnt_q != '1)) begin
            cnt_n = cnt_q + 1'b1;
         end
      end
      // The enable is registered from the next count, so the state path
      // sees only a flop output as its select.
      inj_n = armed_n && run_n &&
              (cnt_n >= {1'b0, time_q}) && (cnt_n <= last_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         armed_q <= 1'b0;
         done_q  <= 1'b0;
         inj_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_n;
         run_q   <= run_n;
         armed_q <= armed_n;
         done_q  <= done_n;
         inj_q   <= inj_n;
      end
   end

   assign armed_o = armed_q;
   assign done_o  = done_q;
   assign inj_o   = inj_q;
endmodule

// File: rtl/fti_lane.sv
module fti_lane #(
   parameter int unsigned STATE_W = 128,
   localparam int unsigned KIND_W = STATE_W * fti_pkg::KIND_BITS
) (
   input  logic               inj_i,
   input  logic [KIND_W-1:0]  kind_i,
   input  logic [STATE_W-1:0] state_i,
   output logic [STATE_W-1:0] state_o
);
   import fti_pkg::*;

   for (genvar b = 0; b < STATE_W; b++) begin : g_bit
      fault_kind_e code;
      assign code = fault_kind_e'(kind_i[KIND_BITS*b +: KIND_BITS]);
      assign state_o[b] = inj_i ? fault_bit(state_i[b], code) : state_i[b];
   end
endmodule

// File: rtl/fault_time_injector.sv
module fault_time_injector #(
   parameter int unsigned STATE_W = 128,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned LEN_W   = 8,
   localparam int unsigned KIND_W = STATE_W * fti_pkg::KIND_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_i,
   input  logic [KIND_W-1:0]  cfg_kind_i,
   input  logic [CNT_W-1:0]   cfg_time_i,
   input  logic [LEN_W-1:0]   cfg_len_i,
   input  logic               sync_i,
   input  logic [STATE_W-1:0] state_i,
   output logic [STATE_W-1:0] state_o,
   output logic               armed_o,
   output logic               done_o
);
   if (STATE_W < 1) begin : g_bad_state
      $error("STATE_W must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > CNT_W) begin : g_bad_len
      $error("LEN_W must be in 1..CNT_W so that the window end fits the counter");
   end

   logic [KIND_W-1:0] kind_q;
   logic [CNT_W-1:0]  time_q;
   logic [CNT_W:0]    last_q;
   logic              inj_w;

   fti_cfg #(.STATE_W(STATE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (arm_i),
      .kind_i (cfg_kind_i),
      .time_i (cfg_time_i),
      .len_i  (cfg_len_i),
      .kind_q (kind_q),
      .time_q (time_q),
      .last_q (last_q)
   );

   fti_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (arm_i),
      .sync_i  (sync_i),
      .time_q  (time_q),
      .last_q  (last_q),
      .armed_o (armed_o),
      .done_o  (done_o),
      .inj_o   (inj_w)
   );

   fti_lane #(.STATE_W(STATE_W)) u_lane (
      .inj_i   (inj_w),
      .kind_i  (kind_q),
      .state_i (state_i),
      .state_o (state_o)
   );
endmodule

// File: rtl/fti_check.sv
module fti_check #(
   parameter int unsigned STATE_W = 128
) (
   input logic               clk,
   input logic               rst_n,
   input logic               arm_i,
   input logic [STATE_W-1:0] state_i,
   input logic [STATE_W-1:0] state_o,
   input logic               armed_o,
   input logic               done_o,
   input logic               inj
);
   // R1: an idle block is transparent
   a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !inj |-> (state_o == state_i));

   // R3: arming sets armed and clears done at the next cycle
   a_r3_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (armed_o && !done_o));

   // R6: no fault is applied unless the block is armed
   a_r6_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_o |-> !inj);

   // R9: arming halts the counter, so the following cycle is fault-free
   a_r9_arm_over_sync: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !inj);

   // R7: done and armed never coexist; done rises only as armed falls
   a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed_o && done_o));
   a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $fell(armed_o));
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> done_o);
endmodule

bind fault_time_injector fti_check #(.STATE_W(STATE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arm_i   (arm_i),
   .state_i (state_i),
   .state_o (state_o),
   .armed_o (armed_o),
   .done_o  (done_o),
   .inj     (inj_w)
);

// File: tb/sim_fault_time_injector.sv
`timescale 1ns/100ps
module sim_fault_time_injector;
   localparam int SW = 128;
   localparam int CW = 16;
   localparam int LW = 8;
   localparam int KW = 2 * SW;

   logic          clk = 0, rst_n = 0, arm = 0, sync = 0;
   logic [KW-1:0] kind = '0;
   logic [CW-1:0] tim = '0;
   logic [LW-1:0] len = '0;
   logic [SW-1:0] din = '0;
   wire  [SW-1:0] dout;
   wire           armed, done;

   int    checks = 0, errors = 0;
   bit    fin = 0;
   bit    fixed = 0;
   string req = "R1";

   always #2 clk = ~clk;

   fault_time_injector u0 (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_kind_i(kind),
      .cfg_time_i(tim), .cfg_len_i(len), .sync_i(sync),
      .state_i(din), .state_o(dout), .armed_o(armed), .done_o(done));

   task automatic chk(string r, logic [SW-1:0] act, logic [SW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h t=%0t", r, act, exp, $time);
      end
   endtask

   function automatic logic [SW-1:0] apply(logic [SW-1:0] d, logic [KW-1:0] k);
      logic [SW-1:0] r;
      for (int i = 0; i < SW; i++) begin
         case (k[2*i +: 2])
            2'b01:   r[i] = ~d[i];
            2'b10:   r[i] = 1'b0;
            2'b11:   r[i] = 1'b1;
            default: r[i] = d[i];
         endcase
      end
      return r;
   endfunction

   // Behavioural reference: cycle count since the sync edge
   int m_cnt = 0, m_time = 0, m_last = 0;
   bit m_armed = 0, m_done = 0, m_run = 0;
   logic [KW-1:0] m_kind = '0;

   function automatic bit m_act();
      return m_armed && m_run && (m_cnt >= m_time) && (m_cnt <= m_last);
   endfunction

   always @(posedge clk) begin
      bit a;
      a = m_act();
      if (!rst_n) begin
         m_armed = 0; m_done = 0; m_run = 0; m_cnt = 0;
      end else if (arm) begin
         m_armed = 1; m_done = 0; m_run = 0; m_cnt = 0;
         m_kind = kind; m_time = int'(tim);
         m_last = int'(tim) + ((len == 0) ? 1 : int'(len)) - 1;
      end else if (m_armed) begin
         if (sync) begin
            m_run = 1; m_cnt = 0;
         end else if (a && m_cnt == m_last) begin
            m_armed = 0; m_done = 1; m_run = 0;
         end else if (m_run) begin
            m_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         chk({req, " model state"}, dout, m_act() ? apply(din, m_kind) : din);
         chk({req, " model flags"}, {126'b0, armed, done}, {126'b0, m_armed, m_done});
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
      if (!fixed) din = {$urandom, $urandom, $urandom, $urandom};
   endtask

   task automatic look();
      #0.5;
   endtask

   localparam logic [SW-1:0] P = 128'h0000_0000_0000_0000_0000_0000_0000_000A;
   localparam logic [SW-1:0] E = 128'h8000_0000_0000_0000_0000_0000_0000_000D;

   initial begin
      repeat (3) step();
      look();
      // R8: reset state
      chk("R8 flags in reset", {126'b0, armed, done}, '0);
      chk("R8 passthru in reset", dout, din);
      rst_n = 1;
      step();
      look();
      chk("R8 flags after reset", {126'b0, armed, done}, '0);

      // R2 fault codes: bit0 flip, bit1 stuck0, bit2 stuck1, bit3 none, bit127 stuck1
      kind = '0;
      kind[1:0] = 2'b01; kind[3:2] = 2'b10; kind[5:4] = 2'b11; kind[255:254] = 2'b11;
      tim = 16'd3; len = 8'd2; arm = 1;
      req = "R3";
      step();
      arm = 0;
      look();
      chk("R3 armed after arm", {126'b0, armed, done}, 128'd2);

      fixed = 1; din = P; req = "R6";
      for (int i = 0; i < 4; i++) begin
         step(); look();
         chk("R6 no sync no fault", dout, P);
      end

      // R5: offset 3, length 2
      req = "R5";
      sync = 1; step(); sync = 0;
      for (int k = 0; k < 7; k++) begin
         look();
         chk($sformatf("R5 R2 cycle %0d after sync", k), dout, (k == 3 || k == 4) ? E : P);
         if (k == 5) chk("R7 done set armed cleared", {126'b0, armed, done}, 128'd1);
         step();
      end

      // R7: later sync ignored
      req = "R7";
      sync = 1; step(); sync = 0;
      for (int k = 0; k < 6; k++) begin
         look();
         chk("R7 sync after done ignored", dout, P);
         step();
      end

      // R9: arm and sync together, offset 0
      req = "R9";
      tim = 16'd0; len = 8'd1; arm = 1; sync = 1;
      step(); arm = 0; sync = 0;
      look();
      chk("R9 sync lost to arm", dout, P);
      chk("R9 armed", {126'b0, armed, done}, 128'd2);
      step(); look();
      chk("R9 still quiet", dout, P);
      sync = 1; step(); sync = 0;
      look();
      chk("R5 offset zero first cycle", dout, E);
      step(); look();
      chk("R5 length one ends", dout, P);
      chk("R7 done after single cycle", {126'b0, armed, done}, 128'd1);

      // R4: restart on second sync
      req = "R4";
      tim = 16'd4; len = 8'd1; arm = 1; step(); arm = 0;
      sync = 1; step(); sync = 0;
      step(); step();
      sync = 1; step(); sync = 0;
      step(); look();
      chk("R4 old count abandoned", dout, P);
      step(); step(); step(); look();
      chk("R4 injection from second sync", dout, E);
      step(); look();
      chk("R4 window closed", dout, P);

      // R5: zero length taken as one
      req = "R5";
      tim = 16'd2; len = 8'd0; arm = 1; step(); arm = 0;
      sync = 1; step(); sync = 0;
      step(); step(); look();
      chk("R5 zero length first cycle", dout, E);
      step(); look();
      chk("R5 zero length one cycle only", dout, P);
      chk("R7 done zero length", {126'b0, armed, done}, 128'd1);

      // R5 long stuck window, with R10 mid-cycle change
      tim = 16'd1; len = 8'd20; arm = 1; step(); arm = 0;
      sync = 1; step(); sync = 0;
      for (int k = 0; k < 24; k++) begin
         look();
         chk($sformatf("R5 long window cycle %0d", k), dout, (k >= 1 && k <= 20) ? E : P);
         if (k == 10) begin
            req = "R10"; din = ~P; #0.2;
            chk("R10 mid-cycle change while faulty", dout, apply(~P, kind));
            din = P;
         end
         if (k == 22) begin
            din = ~P; #0.2;
            chk("R10 R1 mid-cycle change while idle", dout, ~P);
            din = P; req = "R5";
         end
         step();
      end

      // Mixed traffic against the model
      fixed = 0; req = "R2";
      for (int n = 0; n < 12; n++) begin
         for (int j = 0; j < KW / 32; j++) kind[32*j +: 32] = $urandom;
         tim = CW'($urandom % 9); len = LW'($urandom % 6); arm = 1;
         step(); arm = 0;
         repeat ($urandom % 3) step();
         sync = 1; step(); sync = 0;
         if (n % 4 == 1) begin
            step(); sync = 1; step(); sync = 0;
         end
         repeat (16) step();
      end

      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!fin) begin
         fin = 1;
         checks++; errors++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule